// File: doc/BRIEF.md
# Flash Program/Erase Status Engine

This block holds the status byte of a serial NOR flash and runs the timed auto sequence behind page program, sector erase and chip erase. A command decoder sends it single-cycle request strobes. The block accepts at most one operation at a time. It counts a parameterised number of cycles, then takes the pass or fail verdict of the modelled cell operation and folds that verdict into the status byte.

The error flags are sticky. While either one is set, no new program or erase starts until a clear-status strobe arrives while the block is idle. The top status bit is an inverted completion bit. A completed operation drives it to 0. An accepted operation, or a clear issued while idle, drives it back to 1. The durations are cycle counts, so a bench can make them short. A select input shortens each duration to four fifths of its nominal length, which models accelerated programming.

Top module: `flash_status_engine`

## Requirements
- R1: The layout of `status_o` is fixed. Bit 0 is ready (1 = ready). Bit 3 is program error, bit 4 is erase error and bit 6 is parallel mode. Bits 1, 2 and 5 always read 0. `busy_o` is always the inverse of bit 0.
- R2: After the asynchronous reset, `status_o` reads 8'h81 and `busy_o` is 0.
- R3: An accepted request raises `busy_o` in the cycle after the request is sampled. `busy_o` then stays high for exactly PROG_CYC, SECT_CYC or CHIP_CYC cycles, depending on the operation.
- R4: If `accel_i` is high in the cycle a request is accepted, the duration becomes (nominal*4)/5 cycles, with a minimum of 1.
- R5: When an operation ends, bit 7 goes to 0 and bit 0 goes to 1, whether the operation passed or failed.
- R6: `cell_ok_i` is sampled in the last busy cycle. If it is 0, a program sets bit 3, and a sector or chip erase sets bit 4.
- R7: Bit 7 returns to 1 when a program or erase is accepted, or when a clear is accepted while idle.
- R8: While bit 3 or bit 4 is set, program and erase requests are refused. `busy_o` stays 0 and `status_o` does not change.
- R9: A clear while idle resets bits 3 and 4. A clear while busy, including in the last busy cycle, is ignored.
- R10: `par_set_i` sets bit 6. Bit 6 stays set until reset, and a clear does not reset it.
- R11: If several requests arrive together, chip erase wins over sector erase, and sector erase wins over program. Requests that arrive while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_req_i | input | 1 | Page program request strobe |
| sect_erase_req_i | input | 1 | Sector erase request strobe |
| chip_erase_req_i | input | 1 | Chip erase request strobe |
| clr_req_i | input | 1 | Clear-status strobe |
| par_set_i | input | 1 | Enter parallel mode (sticky) |
| accel_i | input | 1 | Shortened-duration select, sampled at acceptance |
| cell_ok_i | input | 1 | Pass (1) or fail (0) verdict of the cell operation |
| status_o | output | 8 | Status byte |
| busy_o | output | 1 | Operation in progress |

## Verification
The hardest case to reach is a clear that lands in the same cycle as the end of a failing operation. The clear must not erase the error that the completion sets at that same edge. The bench counts busy cycles at negative edges and can fire the clear in any chosen busy cycle, so it places the clear exactly on the final one. A second hard case is a refused request, which is only visible when nothing changes. Directed error states are set up before such requests, and the random phase keeps the error flags set often by failing about a quarter of all operations.

// File: rtl/fse_pkg.sv
package fse_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_PROG, OP_SECT, OP_CHIP} op_e;
  localparam int unsigned ST_RDY    = 0;
  localparam int unsigned ST_PERR   = 3;
  localparam int unsigned ST_EERR   = 4;
  localparam int unsigned ST_PAR    = 6;
  localparam int unsigned ST_DONE_N = 7;
endpackage

// File: rtl/fse_timer.sv
module fse_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          run_o,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q;
  logic          run_q;

  assign expire_o = run_q && (cnt_q == '0);
  assign run_o    = run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= 1'b1;
    end else if (expire_o) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_NO_RELOAD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !run_q);  // R11
endmodule

// File: rtl/fse_seq.sv
module fse_seq
  import fse_pkg::*;
#(
  parameter int unsigned PROG_CYC = 400,
  parameter int unsigned SECT_CYC = 4000,
  parameter int unsigned CHIP_CYC = 40000,
  parameter int unsigned ACC_NUM  = 4,
  parameter int unsigned ACC_DEN  = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prog_req_i,
  input  logic sect_req_i,
  input  logic chip_req_i,
  input  logic accel_i,
  input  logic err_any_i,
  output logic start_o,
  output logic busy_o,
  output logic done_o,
  output logic done_erase_o
);
  localparam int unsigned NOM [3] = '{PROG_CYC, SECT_CYC, CHIP_CYC};
  localparam int unsigned MAX_AB  = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int unsigned MAX_CYC = (MAX_AB > CHIP_CYC) ? MAX_AB : CHIP_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  logic [CW-1:0] nom_m1 [3];
  logic [CW-1:0] acc_m1 [3];

  for (genvar g = 0; g < 3; g++) begin : g_dur
    localparam int unsigned NV = (NOM[g] > 0) ? NOM[g] : 1;
    localparam int unsigned AV = ((NV * ACC_NUM) / ACC_DEN > 0) ? (NV * ACC_NUM) / ACC_DEN : 1;
    assign nom_m1[g] = CW'(NV - 1);
    assign acc_m1[g] = CW'(AV - 1);
  end

  op_e           req_op, op_q;
  logic [CW-1:0] load_val;
  logic          run;

  always_comb begin
    if (chip_req_i)      req_op = OP_CHIP;
    else if (sect_req_i) req_op = OP_SECT;
    else if (prog_req_i) req_op = OP_PROG;
    else                 req_op = OP_NONE;
  end

  assign start_o = !run && !err_any_i && (req_op != OP_NONE);

  always_comb begin
    unique case (req_op)
      OP_CHIP: load_val = accel_i ? acc_m1[2] : nom_m1[2];
      OP_SECT: load_val = accel_i ? acc_m1[1] : nom_m1[1];
      default: load_val = accel_i ? acc_m1[0] : nom_m1[0];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      op_q <= OP_NONE;
    else if (start_o) op_q <= req_op;
  end

  assign done_erase_o = (op_q != OP_PROG);
  assign busy_o       = run;

  fse_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start_o),
    .load_val_i (load_val),
    .run_o      (run),
    .expire_o   (done_o)
  );

  AST_ERR_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_any_i && !run && (prog_req_i || sect_req_i || chip_req_i)) |=> !run);  // R8
  AST_START_RAISES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> run);  // R3
endmodule

// File: rtl/fse_status.sv
module fse_status
  import fse_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       done_i,
  input  logic       done_erase_i,
  input  logic       busy_i,
  input  logic       cell_ok_i,
  input  logic       clr_i,
  input  logic       par_set_i,
  output logic [7:0] status_o,
  output logic       err_any_o
);
  logic done_n_q, par_q, perr_q, eerr_q, rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_n_q <= 1'b1;
      par_q    <= 1'b0;
      perr_q   <= 1'b0;
      eerr_q   <= 1'b0;
      rdy_q    <= 1'b1;
    end else begin
      if (par_set_i) par_q <= 1'b1;
      if (start_i) begin
        done_n_q <= 1'b1;
        rdy_q    <= 1'b0;
      end else if (done_i) begin
        done_n_q <= 1'b0;
        rdy_q    <= 1'b1;
        if (!cell_ok_i) begin
          if (done_erase_i) eerr_q <= 1'b1;
          else              perr_q <= 1'b1;
        end
      end else if (clr_i && !busy_i) begin
        perr_q   <= 1'b0;
        eerr_q   <= 1'b0;
        done_n_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status_o            = '0;
    status_o[ST_RDY]    = rdy_q;
    status_o[ST_PERR]   = perr_q;
    status_o[ST_EERR]   = eerr_q;
    status_o[ST_PAR]    = par_q;
    status_o[ST_DONE_N] = done_n_q;
  end

  assign err_any_o = perr_q || eerr_q;

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] == 1'b0) && (status_o[2] == 1'b0) && (status_o[5] == 1'b0));  // R1
  AST_B7_FALL_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[ST_DONE_N]) |-> $past(done_i));  // R5
  AST_PAR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(status_o[ST_PAR]) |-> status_o[ST_PAR]);  // R10
  AST_CLR_BUSY_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && busy_i) |=> ((!$past(perr_q) || perr_q) && (!$past(eerr_q) || eerr_q)));  // R9
endmodule

// File: rtl/flash_status_engine.sv
module flash_status_engine #(
  parameter int unsigned PROG_CYC = 400,
  parameter int unsigned SECT_CYC = 4000,
  parameter int unsigned CHIP_CYC = 40000,
  parameter int unsigned ACC_NUM  = 4,
  parameter int unsigned ACC_DEN  = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       prog_req_i,
  input  logic       sect_erase_req_i,
  input  logic       chip_erase_req_i,
  input  logic       clr_req_i,
  input  logic       par_set_i,
  input  logic       accel_i,
  input  logic       cell_ok_i,
  output logic [7:0] status_o,
  output logic       busy_o
);
  logic start, done, done_erase, err_any, busy;

  fse_seq #(
    .PROG_CYC (PROG_CYC),
    .SECT_CYC (SECT_CYC),
    .CHIP_CYC (CHIP_CYC),
    .ACC_NUM  (ACC_NUM),
    .ACC_DEN  (ACC_DEN)
  ) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prog_req_i   (prog_req_i),
    .sect_req_i   (sect_erase_req_i),
    .chip_req_i   (chip_erase_req_i),
    .accel_i      (accel_i),
    .err_any_i    (err_any),
    .start_o      (start),
    .busy_o       (busy),
    .done_o       (done),
    .done_erase_o (done_erase)
  );

  fse_status u_status (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .done_i       (done),
    .done_erase_i (done_erase),
    .busy_i       (busy),
    .cell_ok_i    (cell_ok_i),
    .clr_i        (clr_req_i),
    .par_set_i    (par_set_i),
    .status_o     (status_o),
    .err_any_o    (err_any)
  );

  assign busy_o = busy;

  AST_BUSY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == !status_o[0]);  // R1
endmodule

// File: tb/flash_status_engine_bench.sv
module flash_status_engine_bench;
  localparam int unsigned P_CYC = 10;
  localparam int unsigned S_CYC = 15;
  localparam int unsigned C_CYC = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic prog_req = 0, sect_req = 0, chip_req = 0, clr_req = 0, par_set = 0, accel = 0, cell_ok = 1;
  logic [7:0] status;
  logic busy;

  int n_chk = 0;
  int n_err = 0;
  logic e7 = 1, e6 = 0, e4 = 0, e3 = 0;

  always #2.5 clk = ~clk;

  flash_status_engine #(
    .PROG_CYC (P_CYC), .SECT_CYC (S_CYC), .CHIP_CYC (C_CYC)
  ) u_flash_status_engine (
    .clk_i (clk), .rst_ni (rst_ni),
    .prog_req_i (prog_req), .sect_erase_req_i (sect_req), .chip_erase_req_i (chip_req),
    .clr_req_i (clr_req), .par_set_i (par_set), .accel_i (accel), .cell_ok_i (cell_ok),
    .status_o (status), .busy_o (busy)
  );

  function automatic logic [7:0] exp_stat(input logic bsy);
    return {e7, e6, 1'b0, e4, e3, 2'b00, !bsy};
  endfunction

  function automatic int dur(input logic [2:0] mask, input logic acc);
    int n;
    n = mask[2] ? C_CYC : (mask[1] ? S_CYC : P_CYC);
    return acc ? (n * 4) / 5 : n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // mask = {chip, sect, prog}
  task automatic do_op(input logic [2:0] mask, input logic acc, input logic ok,
                       input int clr_at, input int mid_at, input string tag);
    int d, n;
    d = dur(mask, acc);
    @(negedge clk);
    {chip_req, sect_req, prog_req} = mask;
    accel = acc;
    cell_ok = ok;
    @(negedge clk);
    {chip_req, sect_req, prog_req} = 3'b000;
    accel = 0;
    if (e3 || e4) begin
      chk({tag, " R8 refused busy"}, busy, 0);
      chk({tag, " R8 refused status"}, status, exp_stat(0));
      repeat (2) @(negedge clk);
      chk({tag, " R8 still idle"}, {busy, status}, {1'b0, exp_stat(0)});
    end else begin
      e7 = 1;
      chk({tag, " R7 R1 start status"}, {busy, status}, {1'b1, exp_stat(1)});
      n = 1;
      while (busy && n < d + 4) begin
        if (n == clr_at) clr_req = 1;
        if (n == mid_at) begin chip_req = 1; prog_req = 1; end
        @(negedge clk);
        clr_req = 0; chip_req = 0; prog_req = 0;
        if (busy) n++;
      end
      chk({tag, acc ? " R4 accel duration" : " R3 R11 duration"}, n, d);
      e7 = 0;
      if (!ok) begin
        if (mask[2] || mask[1]) e4 = 1; else e3 = 1;
      end
      chk({tag, " R5 R6 end status"}, {busy, status}, {1'b0, exp_stat(0)});
    end
    cell_ok = 1;
  endtask

  task automatic do_clr(input string tag);
    @(negedge clk);
    clr_req = 1;
    @(negedge clk);
    clr_req = 0;
    e3 = 0; e4 = 0; e7 = 1;
    chk({tag, " R9 R7 clear"}, status, exp_stat(0));
  endtask

  task automatic do_par(input string tag);
    @(negedge clk);
    par_set = 1;
    @(negedge clk);
    par_set = 0;
    e6 = 1;
    chk({tag, " R10 parallel"}, status, exp_stat(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R2 reset status", status, 8'h81);
    chk("R2 R1 reset busy", busy, 0);
    rst_ni = 1;

    do_op(3'b001, 0, 1, -1, -1, "prog pass");
    chk("R5 pass byte", status, 8'h01);
    do_clr("idle clear");
    do_op(3'b010, 1, 1, -1, -1, "sect accel");
    do_op(3'b100, 0, 0, -1, -1, "chip fail");
    chk("R6 erase err byte", status, 8'h11);
    do_op(3'b001, 0, 1, -1, -1, "blocked prog");
    do_op(3'b100, 1, 1, -1, -1, "blocked chip");
    do_clr("err clear");
    do_op(3'b001, 0, 0, P_CYC, -1, "clr last cycle");
    chk("R9 R6 prog err kept", status, 8'h09);
    do_clr("clear prog err");
    do_op(3'b001, 0, 0, 4, -1, "clr mid");
    chk("R9 clear mid ignored", status, 8'h09);
    do_clr("clear again");
    do_op(3'b111, 0, 1, -1, -1, "prio all");
    do_op(3'b011, 0, 1, -1, -1, "prio sect");
    do_op(3'b001, 1, 1, -1, 3, "req while busy");
    do_op(3'b100, 1, 1, -1, -1, "chip accel");
    do_par("par set");
    do_clr("par kept");

    for (int i = 0; i < 60; i++) begin
      int a;
      a = $urandom_range(0, 9);
      if (a < 7)
        do_op(3'($urandom_range(1, 7)), 1'($urandom_range(0, 1)),
              ($urandom_range(0, 3) != 0), -1, -1, "rand op");
      else if (a < 9) do_clr("rand clr");
      else do_par("rand par");
    end

    @(negedge clk);
    rst_ni = 0;
    @(negedge clk);
    e7 = 1; e6 = 0; e4 = 0; e3 = 0;
    chk("R10 R2 reset clears parallel", status, 8'h81);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule